// File: doc/BRIEF.md
# SMBus Register-File Slave

This block is a two-wire SMBus slave that holds a small bank of 8-bit configuration registers. A host controller can read or write them. The block runs on a fast system clock and oversamples SCL and SDA through a synchronizer. It pulls SDA low through an open-drain enable only while SCL is low. The full register contents are always available as a flat parallel bus for downstream control logic.

The block answers only to the 7-bit address 0x69. On the wire that is 0xD2 for a write and 0xD3 for a read. The command byte that follows the address picks the access mode:

- **Indexed single-byte mode** (command bit 7 = 1): bits 6:0 give the register index.
- **Sequential block mode** (command bit 7 = 0): the transfer starts at register 0 and moves upward. A block write carries a byte count before its data. A block read, after a repeated start, returns a count byte first and then the registers in ascending order.

The master may stop after any complete byte.

Top module: `smb_regfile_slave`

## Requirements
- R1: On reset, register i holds (i * 0x11) mod 256, the slave leaves SDA released, and the bus is idle.
- R2: An address byte other than 0xD2 or 0xD3 gets no acknowledge. No later byte of that transfer is acknowledged, and the transfer changes no register.
- R3: A write with command bit 7 = 1 stores the first data byte into the register indexed by command bits 6:0. Further data bytes in the same transfer are acknowledged and discarded.
- R4: A write of a command with bit 7 = 1, then a repeated start and the read address 0xD3, returns the indexed register, sent most significant bit first.
- R5: A write with command 0x00 takes the next byte as a count N. It then stores the following N data bytes into registers 0 to N-1. Data bytes beyond N are acknowledged and discarded.
- R6: Command 0x00, then a repeated start and the read address, returns first the register count (0x10) and then registers 0, 1, 2 and onward. After the master's NACK the slave leaves SDA released.
- R7: A write to an index of 16 or more is acknowledged and changes no register. A read from such an index returns 0x00.
- R8: A stop after any complete byte ends the transfer. Bytes already completed stay written, no other register changes, SDA is released the cycle after the stop is detected, and the next transfer works normally.
- R9: The slave changes its SDA drive only while the synchronized SCL is low.
- R10: Every byte the addressed slave receives is acknowledged by SDA held low during the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_q | output | NREG*8 | All registers, register i on bits [8i+7:8i] |

## Verification
Four behaviours are checked on every cycle:
- the SDA drive moves only while the synchronized SCL is low;
- a stop always releases SDA on the next cycle;
- register contents change only in the cycle after an SCL falling edge;
- registers stay frozen while the slave is transmitting.

Some behaviours only the bench scenarios can show. These are address rejection, the split between indexed and block modes, discarding past the byte count or out of range, the count byte that leads a block read, and the outcome of a stop in mid-block. The behavioural register model catches any mismatch in the cycles where SCL is high.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXACK,
      ST_TX,
      ST_TXACK,
      ST_SKIP
   } smb_state_e;

   typedef enum logic [1:0] {
      FLD_ADDR,
      FLD_CMD,
      FLD_CNT,
      FLD_DATA
   } smb_field_e;

   localparam int unsigned IDX_W = 7;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smb_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_d,
   output logic stop_d,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign start_d  = scl_p & scl_s & sda_p & ~sda_s;
   assign stop_d   = scl_p & scl_s & ~sda_p & sda_s;
   assign scl_rise = ~scl_p & scl_s;
   assign scl_fall = scl_p & ~scl_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
   parameter int unsigned NREG     = 16,
   parameter int unsigned DW       = 8,
   parameter int unsigned IDXW     = 7,
   parameter logic [7:0]  DEF_STEP = 8'h11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDXW-1:0]    waddr,
   input  logic [DW-1:0]      wdata,
   input  logic [IDXW-1:0]    raddr,
   output logic [DW-1:0]      rdata,
   output logic [NREG*DW-1:0] regs_flat
);
   logic [DW-1:0] mem [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] RST_VAL = DW'((i * DEF_STEP) % 256);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         mem[i] <= RST_VAL;
         else if (we && waddr == IDXW'(i))   mem[i] <= wdata;
      end
      assign regs_flat[i*DW +: DW] = mem[i];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (raddr == IDXW'(i)) rdata = mem[i];
   end
endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave
   import smb_slave_pkg::*;
#(
   parameter logic [6:0]  SLV_ADDR    = 7'h69,
   parameter int unsigned NREG        = 16,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  DEF_STEP    = 8'h11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               sda_oe,
   output logic [NREG*DW-1:0] regs_q
);
   localparam logic [7:0] CNT_BYTE = 8'(NREG);

   if (DW != 8) begin : g_bad_dw
      $error("smb_regfile_slave: DW must be 8");
   end
   if (NREG < 1 || NREG > 128) begin : g_bad_nreg
      $error("smb_regfile_slave: NREG must be 1..128");
   end

   logic scl_s, sda_s;
   logic start_d, stop_d, scl_rise, scl_fall;

   smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
   );

   smb_cond_detect u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_d(start_d), .stop_d(stop_d), .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   smb_state_e       state;
   smb_field_e       field;
   logic [3:0]       bitcnt;
   logic [7:0]       rx_sh, tx_sh, rem;
   logic [IDX_W-1:0] ptr;
   logic             blk, rd_pend, rd_first, nack;
   logic             byte_done, wr_en, tx_active, load_cnt;
   logic [DW-1:0]    rd_data;

   assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
   assign wr_en     = byte_done && (field == FLD_DATA) && (rem != 8'd0)
                      && !start_d && !stop_d;
   assign tx_active = (state == ST_TX);
   assign load_cnt  = blk && rd_first;
   assign sda_oe    = (state == ST_RXACK) || (tx_active && !tx_sh[7]);

   smb_regbank #(.NREG(NREG), .DW(DW), .IDXW(IDX_W), .DEF_STEP(DEF_STEP)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(rx_sh),
      .raddr(ptr), .rdata(rd_data), .regs_flat(regs_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         field    <= FLD_ADDR;
         bitcnt   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '1;
         rem      <= '0;
         ptr      <= '0;
         blk      <= 1'b0;
         rd_pend  <= 1'b0;
         rd_first <= 1'b0;
         nack     <= 1'b0;
      end else if (stop_d) begin
         state <= ST_IDLE;
      end else if (start_d) begin
         state  <= ST_RX;
         field  <= FLD_ADDR;
         bitcnt <= '0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  rx_sh  <= {rx_sh[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  bitcnt  <= '0;
                  state   <= ST_RXACK;
                  rd_pend <= 1'b0;
                  unique case (field)
                     FLD_ADDR: begin
                        if (rx_sh[7:1] == SLV_ADDR) begin
                           rd_pend  <= rx_sh[0];
                           rd_first <= 1'b1;
                           field    <= FLD_CMD;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end
                     FLD_CMD: begin
                        blk   <= ~rx_sh[7];
                        ptr   <= rx_sh[7] ? rx_sh[6:0] : '0;
                        rem   <= 8'd1;
                        field <= rx_sh[7] ? FLD_DATA : FLD_CNT;
                     end
                     FLD_CNT: begin
                        rem   <= rx_sh;
                        field <= FLD_DATA;
                     end
                     FLD_DATA: begin
                        if (rem != 8'd0) begin
                           rem <= rem - 8'd1;
                           ptr <= ptr + 1'b1;
                        end
                     end
                  endcase
               end
            end
            ST_RXACK, ST_TXACK: begin
               if (state == ST_TXACK && scl_rise) nack <= sda_s;
               if (scl_fall) begin
                  if ((state == ST_RXACK && !rd_pend) ) begin
                     state <= ST_RX;
                  end else if (state == ST_TXACK && nack) begin
                     state <= ST_SKIP;
                  end else begin
                     state  <= ST_TX;
                     bitcnt <= '0;
                     tx_sh  <= load_cnt ? CNT_BYTE : rd_data;
                     if (load_cnt) rd_first <= 1'b0;
                     else          ptr      <= ptr + 1'b1;
                  end
               end
            end
            ST_TX: begin
               if (scl_rise) bitcnt <= bitcnt + 4'd1;
               else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     state <= ST_TXACK;
                     tx_sh <= '1;
                  end else begin
                     tx_sh <= {tx_sh[6:0], 1'b1};
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk #(
   parameter int unsigned W = 128
) (
   input logic         clk,
   input logic         rst_n,
   input logic         scl_s,
   input logic         stop_d,
   input logic         scl_fall,
   input logic         tx_active,
   input logic         sda_oe,
   input logic [W-1:0] regs_q
);
   a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   a_r8_stop_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
      stop_d |=> !sda_oe);

   a_r5_write_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_q) |-> $past(scl_fall));

   a_r6_regs_frozen_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |-> $stable(regs_q));
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(.W(NREG*DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_d(stop_d), .scl_fall(scl_fall),
   .tx_active(tx_active), .sda_oe(sda_oe), .regs_q(regs_q)
);

// File: tb/test_smb_regfile_slave.sv
module test_smb_regfile_slave;
   localparam int NREG = 16;

   logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
   wire  sda_oe;
   wire  [NREG*8-1:0] regs_q;
   wire  sda_line = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   smb_regfile_slave i_smb_regfile_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .sda_oe(sda_oe), .regs_q(regs_q)
   );

   int checks = 0, bad = 0;
   logic [7:0] exp_r [NREG];
   int m_ptr = 0, m_rem = 0;
   bit cmp_on = 0, done = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   // model compared every clock while SCL is high (R3 R5 R7 R8)
   always @(negedge clk) begin
      if (cmp_on && m_scl) begin
         int mism = 0;
         for (int i = 0; i < NREG; i++)
            if (regs_q[i*8 +: 8] != exp_r[i]) mism++;
         checks++;
         if (mism != 0) begin
            bad++;
            if (bad < 10) $display("FAIL R3/R5 model mismatch actual=%0h expected_regs_differ=%0d", regs_q, mism);
         end
      end
   end

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic start_c();
      m_sda = 1; m_scl = 1; tick(8); m_sda = 0; tick(8); m_scl = 0; tick(4);
   endtask
   task automatic rstart_c();
      tick(2); m_sda = 1; tick(6); m_scl = 1; tick(8); m_sda = 0; tick(8); m_scl = 0; tick(4);
   endtask
   task automatic stop_c();
      tick(2); m_sda = 0; tick(6); m_scl = 1; tick(8); m_sda = 1; tick(8);
   endtask
   task automatic wbit(input bit b);
      tick(2); m_sda = b; tick(6); m_scl = 1; tick(8); m_scl = 0;
   endtask
   task automatic rbit(output bit b);
      tick(2); m_sda = 1; tick(6); m_scl = 1; tick(4); b = sda_line; tick(4); m_scl = 0;
   endtask

   task automatic model_data(input logic [7:0] v);
      if (m_rem > 0) begin
         if (m_ptr < NREG) exp_r[m_ptr] = v;
         m_ptr++; m_rem--;
      end
   endtask

   task automatic wbyte(input logic [7:0] v, input bit is_data, output bit ack);
      bit a;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      if (is_data) model_data(v);
      rbit(a);
      ack = !a;
   endtask

   task automatic rbyte(input bit last, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
      wbit(last);
   endtask

   task automatic header(input logic [7:0] cmd);
      bit a;
      start_c();
      wbyte(8'hD2, 0, a); chk("R10 address ack", a, 1);
      wbyte(cmd, 0, a);   chk("R10 command ack", a, 1);
      if (cmd[7]) begin m_ptr = cmd[6:0]; m_rem = 1; end
      else begin m_ptr = 0; m_rem = 0; end
   endtask

   initial begin
      bit a;
      logic [7:0] v;
      tick(5); rst_n = 1; tick(5);
      // R1 reset defaults
      for (int i = 0; i < NREG; i++) begin
         exp_r[i] = 8'((i * 17) % 256);
         chk("R1 reset value", regs_q[i*8 +: 8], exp_r[i]);
      end
      chk("R1 sda released", sda_oe, 0);
      cmp_on = 1;

      // R3 byte write with an extra byte discarded
      header(8'h85);
      wbyte(8'hA5, 1, a); chk("R3 data ack", a, 1);
      wbyte(8'h5A, 1, a); chk("R3 extra byte ack", a, 1);
      stop_c();
      chk("R3 reg5 written", regs_q[5*8 +: 8], 8'hA5);
      chk("R3 reg6 untouched", regs_q[6*8 +: 8], 8'h66);

      // R4 byte reads
      header(8'h85); rstart_c();
      wbyte(8'hD3, 0, a); chk("R4 read address ack", a, 1);
      rbyte(1, v); stop_c(); chk("R4 read reg5", v, 8'hA5);
      header(8'h83); rstart_c(); wbyte(8'hD3, 0, a);
      rbyte(1, v); stop_c(); chk("R4 read reg3", v, 8'h33);

      // R5 block write count 3, fourth byte discarded
      header(8'h00);
      wbyte(8'd3, 0, a); chk("R5 count ack", a, 1); m_rem = 3;
      wbyte(8'hC0, 1, a); wbyte(8'hC1, 1, a); wbyte(8'hC2, 1, a);
      wbyte(8'hEE, 1, a); chk("R5 surplus byte ack", a, 1);
      stop_c();
      chk("R5 reg2", regs_q[2*8 +: 8], 8'hC2);
      chk("R5 reg3 kept", regs_q[3*8 +: 8], 8'h33);

      // R6 block read: count then registers
      header(8'h00); rstart_c(); wbyte(8'hD3, 0, a);
      rbyte(0, v); chk("R6 count byte", v, 8'h10);
      for (int i = 0; i < 5; i++) begin
         rbyte(i == 4, v); chk("R6 block read data", v, exp_r[i]);
      end
      tick(6); chk("R6 released after nack", sda_oe, 0);
      stop_c();

      // R2 foreign address
      start_c();
      wbyte(8'hA0, 0, a); chk("R2 foreign address nack", a, 0);
      wbyte(8'h81, 0, a); chk("R2 later byte nack", a, 0);
      wbyte(8'h77, 0, a); chk("R2 data nack", a, 0);
      stop_c();
      chk("R2 reg1 unchanged", regs_q[1*8 +: 8], exp_r[1]);

      // R7 out of range
      header(8'hA0);
      wbyte(8'h99, 1, a); chk("R7 out-of-range write ack", a, 1);
      stop_c();
      header(8'hA0); rstart_c(); wbyte(8'hD3, 0, a);
      rbyte(1, v); stop_c(); chk("R7 out-of-range read", v, 0);

      // R8 stop mid block
      header(8'h00);
      wbyte(8'd4, 0, a); m_rem = 4;
      wbyte(8'h71, 1, a); wbyte(8'h72, 1, a);
      stop_c();
      tick(1); chk("R8 sda released after stop", sda_oe, 0);
      chk("R8 reg1 written", regs_q[1*8 +: 8], 8'h72);
      chk("R8 reg2 kept", regs_q[2*8 +: 8], 8'hC2);
      header(8'h8F);
      wbyte(8'h3C, 1, a); chk("R8 next transfer ack", a, 1);
      stop_c();
      chk("R8 next transfer write", regs_q[15*8 +: 8], 8'h3C);

      tick(10);
      finish_up();
   end
endmodule